// File: doc/BRIEF.md
# Block Write-Protection Lock Controller

This block keeps the write-protection state of every erase block in a flash array. Each block is in one of three states: unlocked, locked, or lock-tight. Software first sets a block range through two small registers, a first-block register and a last-block register. It then issues one of four commands: unlock the range, lock the range, lock-tight the range, or unlock every block. A walker visits one block per clock, reads the block's current state and decides whether to rewrite it. Some conditions end the walk early. When the walk ends, the controller pulses `done`.

A lock-tight block cannot be unlocked or locked by any later command. Only a cold reset clears it, and a reset puts every block back to locked. Writing the first-block register also copies the value into the last-block register, so a one-block range needs a single write. A status word holds the state most recently written to any block. A sticky error flag reports a walk that ran past the last real block. A separate lookup port returns the state of any one block, so that program and erase logic elsewhere can check it.

Top module: `wp_lock_ctrl`

## Requirements
- R1: After reset every block reads locked (2). `wp_status` is 0x0002, and `busy`, `done`, `cmd_err`, `unl_start` and `unl_end` are all 0.
- R2: A register write with `reg_sel`=0 stores `reg_wdata[IDX_W-1:0]` into both `unl_start` and `unl_end`. A write with `reg_sel`=1 stores it into `unl_end` only. IDX_W is clog2(NUM_BLOCKS), which is 4 by default.
- R3: `cmd_op`=0 (unlock range) sets each block from start to end, inclusive, to unlocked (4). It ends at the first lock-tight block, which stays as it is along with every block after it.
- R4: `cmd_op`=1 (lock range) sets each block in the range to locked (2), with the same stop at the first lock-tight block.
- R5: `cmd_op`=2 (lock-tight range) sets every block in the range that is not unlocked to lock-tight (1) and passes over unlocked blocks without changing them.
- R6: `cmd_op`=3 (unlock all) walks from block 0 to block NUM_BLOCKS-1, setting blocks to unlocked, and stops at the first lock-tight block.
- R7: If a walk reaches a block index of NUM_BLOCKS or more, it ends there and `cmd_err` goes to 1. Blocks visited before that point keep their new states. `cmd_err` clears when the next command is accepted.
- R8: Each block write copies the written state code into `wp_status`, zero-extended. A command that writes no block leaves `wp_status` unchanged.
- R9: `busy` is high for one cycle per block visited without stopping, plus one final cycle. `done` is then a one-cycle pulse with `busy` low. This also holds for an early stop and for an empty range (end below start).
- R10: Commands and register writes presented while `busy` is high have no effect.
- R11: `lk_state` returns, combinationally, the current state of block `lk_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| reg_wr_en | input | 1 | Range register write strobe |
| reg_sel | input | 1 | 0 = first-block register (also copies to last), 1 = last-block register |
| reg_wdata | input | 16 | Register write data; the low IDX_W bits are kept |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_op | input | 2 | 0 unlock range, 1 lock range, 2 lock-tight range, 3 unlock all |
| lk_idx | input | IDX_W | Block index for the lookup port |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at walk end |
| cmd_err | output | 1 | Walk reached an index beyond the array |
| wp_status | output | 16 | Last state code written to a block |
| unl_start | output | IDX_W | First-block register |
| unl_end | output | IDX_W | Last-block register |
| lk_state | output | 3 | State code of block `lk_idx` |

## Verification
The assertions check several properties on every cycle:
- `done` lasts one cycle and comes only after a busy walk.
- The error flag rises only together with `done`.
- The status code is always one valid state.
- The range registers and the latched command stay frozen while the walker runs.
- A lock-tight block is only ever rewritten as lock-tight.

Some behaviour only the bench scenarios can show, because it depends on the contents of the whole array. This covers the exact walk length and where a walk stops at a lock-tight block or at the array edge. It also covers the skipping of unlocked blocks by lock-tight, the outcome of the unlock-all walk, and the final per-block states.

// File: rtl/wp_lock_pkg.sv
// Shared types for the write-protection lock controller.
// Assumes state codes are one-hot so that a status word decodes one state.
package wp_lock_pkg;
    typedef enum logic [2:0] {
        WP_TIGHT    = 3'b001,
        WP_LOCKED   = 3'b010,
        WP_UNLOCKED = 3'b100
    } wp_state_e;

    typedef enum logic [1:0] {
        OP_UNLOCK_RANGE = 2'd0,
        OP_LOCK_RANGE   = 2'd1,
        OP_TIGHTEN      = 2'd2,
        OP_UNLOCK_ALL   = 2'd3
    } wp_op_e;
endpackage

// File: rtl/wp_range_regs.sv
// Holds the first-block and last-block range registers.
// Assumes the walker latches the range at command accept; writes are dropped while busy.
module wp_range_regs #(
    parameter int REG_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             busy,
    output logic [IDX_W-1:0] start_o,
    output logic [IDX_W-1:0] end_o
);
    logic [IDX_W-1:0] start_q, end_q;
    logic             unused_hi;

    assign unused_hi = ^wr_data[REG_W-1:IDX_W];

    // Range register update; a first-block write also sets the last block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (wr_en && !busy) begin
            if (!wr_sel) begin
                start_q <= wr_data[IDX_W-1:0];
                end_q   <= wr_data[IDX_W-1:0];
            end else begin
                end_q   <= wr_data[IDX_W-1:0];
            end
        end
    end

    assign start_o = start_q;
    assign end_o   = end_q;

    // R10: range registers frozen during a walk
    a_r10_range_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(start_q) && $stable(end_q)));
    // R2: a first-block write leaves both registers equal
    a_r2_start_copies_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && !wr_sel) |=> (start_q == end_q));
endmodule

// File: rtl/wp_state_mem.sv
// Per-block lock state store: one register per block, one write port,
// a walker read port and a lookup read port. Cold reset locks every block.
// Assumes reads at indices beyond the array are never used for decisions.
module wp_state_mem
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4,
    parameter int CW         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  wp_state_e        wr_state,
    input  logic [CW-1:0]    walk_idx,
    output wp_state_e        walk_state,
    input  logic [IDX_W-1:0] look_idx,
    output wp_state_e        look_state
);
    localparam logic [CW-1:0]    NB_C  = CW'(NUM_BLOCKS);
    localparam logic [IDX_W:0]   NB_L  = (IDX_W + 1)'(NUM_BLOCKS);

    wp_state_e mem_q [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        // One block's state register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= WP_LOCKED;
            else if (wr_en && wr_idx == IDX_W'(g))
                mem_q[g] <= wr_state;
        end
    end

    // Walker and lookup reads, guarded against indices past the array.
    always_comb begin
        walk_state = (walk_idx < NB_C) ? mem_q[walk_idx[IDX_W-1:0]] : WP_LOCKED;
        look_state = ({1'b0, look_idx} < NB_L) ? mem_q[look_idx] : WP_LOCKED;
    end

    // R5: a lock-tight block is never rewritten to another state
    a_r5_tight_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} < NB_L) && mem_q[wr_idx] == WP_TIGHT) |-> (wr_state == WP_TIGHT));
endmodule

// File: rtl/wp_walker.sv
// Range walker: accepts a command when idle, visits one block per clock,
// rewrites states per the command, stops at range end, at a lock-tight
// block (lock/unlock) or at an index past the array (error), then pulses done.
// Assumes cur_state is the combinational state of block walk_idx.
module wp_walker
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4,
    parameter int CW         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  wp_op_e           cmd_op,
    input  logic [IDX_W-1:0] start_i,
    input  logic [IDX_W-1:0] end_i,
    input  wp_state_e        cur_state,
    output logic [CW-1:0]    walk_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output wp_state_e        wr_state,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [2:0]       status
);
    localparam logic [CW-1:0] NB_C   = CW'(NUM_BLOCKS);
    localparam logic [CW-1:0] LAST_C = CW'(NUM_BLOCKS - 1);

    logic          busy_q, done_q, err_q;
    logic [CW-1:0] cur_q, last_q;
    wp_op_e        op_q;
    logic [2:0]    status_q;
    logic          stop, err_set;

    // Per-visit decision: write, skip, or stop.
    always_comb begin
        wr_en    = 1'b0;
        wr_state = WP_LOCKED;
        stop     = 1'b0;
        err_set  = 1'b0;
        if (busy_q) begin
            if (cur_q > last_q) begin
                stop = 1'b1;
            end else if (cur_q >= NB_C) begin
                stop    = 1'b1;
                err_set = 1'b1;
            end else begin
                unique case (op_q)
                    OP_UNLOCK_RANGE, OP_UNLOCK_ALL: begin
                        if (cur_state == WP_TIGHT) stop = 1'b1;
                        else begin wr_en = 1'b1; wr_state = WP_UNLOCKED; end
                    end
                    OP_LOCK_RANGE: begin
                        if (cur_state == WP_TIGHT) stop = 1'b1;
                        else begin wr_en = 1'b1; wr_state = WP_LOCKED; end
                    end
                    OP_TIGHTEN: begin
                        if (cur_state != WP_UNLOCKED) begin
                            wr_en = 1'b1; wr_state = WP_TIGHT;
                        end
                    end
                    default: stop = 1'b1;
                endcase
            end
        end
    end

    // Command accept, walk advance, end-of-walk pulse and status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            cur_q    <= '0;
            last_q   <= '0;
            op_q     <= OP_UNLOCK_RANGE;
            status_q <= WP_LOCKED;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (cmd_valid) begin
                    busy_q <= 1'b1;
                    err_q  <= 1'b0;
                    op_q   <= cmd_op;
                    if (cmd_op == OP_UNLOCK_ALL) begin
                        cur_q  <= '0;
                        last_q <= LAST_C;
                    end else begin
                        cur_q  <= {1'b0, start_i};
                        last_q <= {1'b0, end_i};
                    end
                end
            end else begin
                if (wr_en) status_q <= wr_state;
                if (stop) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    if (err_set) err_q <= 1'b1;
                end else begin
                    cur_q <= cur_q + 1'b1;
                end
            end
        end
    end

    assign walk_idx = cur_q;
    assign wr_idx   = cur_q[IDX_W-1:0];
    assign busy     = busy_q;
    assign done     = done_q;
    assign err      = err_q;
    assign status   = status_q;

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R9: done only follows a busy cycle and comes with busy low
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));
    // R7: the error flag rises only at the end of a walk
    a_r7_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> done_q);
    // R8: status always holds exactly one valid state code
    a_r8_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_q) == 1);
    // R10: the latched command does not change during a walk
    a_r10_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($stable(op_q) && $stable(last_q)));
endmodule

// File: rtl/wp_lock_ctrl.sv
// Top of the block write-protection lock controller: range registers,
// per-block state store and the range walker.
// Assumes a single clock domain and a synchronous active-low cold reset.
module wp_lock_ctrl
    import wp_lock_pkg::*;
#(
    parameter  int NUM_BLOCKS = 12,
    parameter  int REG_W      = 16,
    localparam int IDX_W      = $clog2(NUM_BLOCKS),
    localparam int CW         = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             busy,
    output logic             done,
    output logic             cmd_err,
    output logic [REG_W-1:0] wp_status,
    output logic [IDX_W-1:0] unl_start,
    output logic [IDX_W-1:0] unl_end,
    output logic [2:0]       lk_state
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    wp_state_e        wr_state, walk_state, look_state;
    logic [CW-1:0]    walk_idx;
    logic [2:0]       status3;

    wp_range_regs #(.REG_W(REG_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_sel),
        .wr_data(reg_wdata), .busy(busy), .start_o(unl_start), .end_o(unl_end)
    );

    wp_state_mem #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .CW(CW)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
        .walk_idx(walk_idx), .walk_state(walk_state),
        .look_idx(lk_idx), .look_state(look_state)
    );

    wp_walker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(wp_op_e'(cmd_op)),
        .start_i(unl_start), .end_i(unl_end), .cur_state(walk_state),
        .walk_idx(walk_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
        .busy(busy), .done(done), .err(cmd_err), .status(status3)
    );

    assign wp_status = {{(REG_W-3){1'b0}}, status3};
    assign lk_state  = look_state;
endmodule

// File: tb/test_wp_lock_ctrl.sv
// Self-checking bench: directed corners plus seeded random commands,
// compared against a bench-side model of the per-block states.
module test_wp_lock_ctrl;
    localparam int NB = 12;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0, reg_sel = 1'b0, cmd_valid = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [1:0]    cmd_op = '0;
    logic [IW-1:0] lk_idx = '0;
    logic          busy, done, cmd_err;
    logic [15:0]   wp_status;
    logic [IW-1:0] unl_start, unl_end;
    logic [2:0]    lk_state;

    int total = 0, bad = 0, cycles = 0;
    int m_state [NB];
    int m_start = 0, m_end = 0, m_status = 2, m_err = 0;

    wp_lock_ctrl #(.NUM_BLOCKS(NB)) i_wp_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .lk_idx(lk_idx),
        .busy(busy), .done(done), .cmd_err(cmd_err), .wp_status(wp_status),
        .unl_start(unl_start), .unl_end(unl_end), .lk_state(lk_state)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) m_state[b] = 2;
        m_start = 0; m_end = 0; m_status = 2; m_err = 0;
    endtask

    task automatic model_cmd(input int op, output int cyc);
        int first, last;
        m_err = 0;
        first = (op == 3) ? 0 : m_start;
        last  = (op == 3) ? NB - 1 : m_end;
        cyc = 1;
        for (int b = first; b <= last; b++) begin
            if (b >= NB) begin m_err = 1; break; end
            if (op == 2) begin
                if (m_state[b] != 4) begin m_state[b] = 1; m_status = 1; end
            end else begin
                if (m_state[b] == 1) break;
                m_state[b] = (op == 1) ? 2 : 4;
                m_status = m_state[b];
            end
            cyc++;
        end
    endtask

    // Checks every block through the lookup port (R11) against the model.
    task automatic check_blocks(input string req);
        int mism = 0, first_bad = -1, act = 0;
        for (int b = 0; b < NB; b++) begin
            lk_idx = IW'(b);
            #1;
            if (int'(lk_state) != m_state[b]) begin
                mism++;
                if (first_bad < 0) begin first_bad = b; act = int'(lk_state); end
            end
        end
        check(mism == 0, {req, "/R11 block states"}, act,
              (first_bad < 0) ? 0 : m_state[first_bad]);
    endtask

    task automatic reg_write(input bit sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (!sel) begin m_start = int'(d[IW-1:0]); m_end = m_start; end
        else m_end = int'(d[IW-1:0]);
        check(int'(unl_start) == m_start && int'(unl_end) == m_end, "R2 range regs",
              int'({unl_start, unl_end}), (m_start << IW) | m_end);
    endtask

    task automatic run_cmd(input int op, input string req);
        int exp_cyc, got = 0, guard = 0;
        model_cmd(op, exp_cyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && guard < 100) begin
            if (busy) got++;
            guard++;
            @(negedge clk);
        end
        check(done && !busy, "R9 done pulse with busy low", int'(done), 1);
        check(got == exp_cyc, "R9 busy length", got, exp_cyc);
        check(int'(cmd_err) == m_err, {req, "/R7 cmd_err"}, int'(cmd_err), m_err);
        check(int'(wp_status) == m_status, {req, "/R8 wp_status"}, int'(wp_status), m_status);
        check_blocks(req);
        @(negedge clk);
        check(!done, "R9 done one cycle", int'(done), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check(!busy && !done && !cmd_err, "R1 control outputs", int'({busy, done, cmd_err}), 0);
        check(wp_status == 16'h0002, "R1 wp_status", int'(wp_status), 2);
        check(unl_start == '0 && unl_end == '0, "R1 range regs", int'({unl_start, unl_end}), 0);
        check_blocks("R1");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2: mask to index width, start copies into end; end alone
        reg_write(1'b0, 16'hFFF3);
        reg_write(1'b1, 16'h0007);
        // R3: unlock 3..7
        run_cmd(0, "R3 unlock range");
        // R5: lock-tight 1..4, 3 and 4 are unlocked and skipped
        reg_write(1'b0, 16'd1);
        reg_write(1'b1, 16'd4);
        run_cmd(2, "R5 lock-tight skips unlocked");
        // R3: unlock 0..6 stops at tight block 1
        reg_write(1'b0, 16'd0);
        reg_write(1'b1, 16'd6);
        run_cmd(0, "R3 stop at lock-tight");
        // R4: lock 3..5
        reg_write(1'b0, 16'd3);
        reg_write(1'b1, 16'd5);
        run_cmd(1, "R4 lock range");
        // R4: lock range starting on a tight block changes nothing
        reg_write(1'b0, 16'd2);
        run_cmd(1, "R4 stop at lock-tight");
        // R6: unlock all stops at block 1
        run_cmd(3, "R6 unlock all early stop");
        // R7: range 10..14 overruns the array
        reg_write(1'b0, 16'd10);
        reg_write(1'b1, 16'd14);
        run_cmd(1, "R7 overrun error");
        // R7: next command clears the error; R8: empty range keeps status
        reg_write(1'b0, 16'd6);
        reg_write(1'b1, 16'd2);
        run_cmd(0, "R8 empty range");

        // R1: cold reset relocks everything, including tight blocks
        do_reset();
        // R10: command and register write during a walk are ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1;
        reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 16'd5;
        @(negedge clk);
        cmd_valid = 1'b0; reg_wr_en = 1'b0;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        begin
            int c;
            model_cmd(3, c);
        end
        check(done, "R10 walk completes", int'(done), 1);
        check(unl_start == '0, "R10 register write ignored", int'(unl_start), 0);
        repeat (3) @(negedge clk);
        check(!busy, "R10 command ignored", int'(busy), 0);
        check_blocks("R10 R6 unlock all");

        // Random mix
        for (int it = 0; it < 80; it++) begin
            int pick = int'($urandom_range(0, 4));
            if (pick == 0) reg_write(1'b0, 16'($urandom()));
            else if (pick == 1) reg_write(1'b1, 16'($urandom()));
            else run_cmd(int'($urandom_range(0, 3)), "R3 R4 R5 R6 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule